// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Sequencer

This block owns the row and column strobes of an asynchronous DRAM whenever no host access holds the bus. Out of reset it waits out the power-on pause and then runs a fixed number of wake-up strobe cycles. After that it keeps the array alive by running CAS-before-RAS refresh cycles, one for each tick of a free-running interval timer. In these cycles the column strobe falls first, so the device picks the row itself and the address pins carry no meaning. Write enable and output enable stay high and the address bus stays at zero.

An access controller asks for the bus with a level request. It receives a grant and hands the bus back with a one-cycle done pulse. A tick that arrives while the bus is granted is not lost: a pending counter records it, and the postponed refreshes are run back to back once the bus returns. When the backlog reaches an urgency level, refresh wins over a waiting request. If the backlog ever reaches a full window's worth of rows, the retention window has been missed. The sequencer then withdraws the ready flag and repeats the wake-up sequence. Every strobe interval is derived from nanosecond parameters and the clock period, each rounded up to whole cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While rst_ni is low, ras_no and cas_no are 1, and acc_gnt_o and init_done_o are 0.
- R2: After reset is released, both strobes stay high for at least PAUSE_CYC = ceil(PAUSE_US*1000/CLK_NS) cycles. The first column-strobe fall comes no more than two cycles after that.
- R3: Exactly WAKE_CYCLES strobe cycles run before init_done_o rises. acc_gnt_o is never 1 while init_done_o is 0.
- R4: Every cycle is CAS-before-RAS. cas_no falls while ras_no is high, and stays low for exactly CSU_CYC = max(1, ceil(T_CSR_NS/CLK_NS)) cycles before ras_no falls. cas_no is still low when ras_no falls.
- R5: ras_no stays low for exactly RAS_CYC = ceil(T_RAS_NS/CLK_NS) cycles, and cas_no rises on the same clock edge as ras_no.
- R6: Both strobes stay high for at least PRE_CYC = max(ceil(T_RP_NS/CLK_NS), ceil(T_RC_NS/CLK_NS) - RAS_CYC) cycles before the next column-strobe fall and before acc_gnt_o rises.
- R7: With no host traffic after wake-up, consecutive refresh cycles start exactly TICK_CYC = floor(REF_WIN_US*1000/(REF_ROWS*CLK_NS)) cycles apart.
- R8: When idle with no backlog, a held acc_req_i is granted. acc_gnt_o stays 1 until acc_done_i and falls on the next edge. Both strobes stay high while it is 1.
- R9: When the backlog is at or above URGENT_LVL and below REF_ROWS, a pending request waits. Refreshes run until the backlog drops below URGENT_LVL, and only then is the grant given.
- R10: If the bus is held across H interval ticks (with H below URGENT_LVL), exactly H refresh cycles follow the release, spaced 12 cycles apart at the default strobe timing.
- R11: If the backlog reaches REF_ROWS, init_done_o falls when the bus is next free. WAKE_CYCLES strobe cycles are then repeated before init_done_o rises again.
- R12: we_no and oe_no are always 1 and addr_o is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_req_i | input | 1 | Access controller asks for the bus (level) |
| acc_done_i | input | 1 | One-cycle pulse: access controller returns the bus |
| acc_gnt_o | output | 1 | Bus granted to the access controller |
| init_done_o | output | 1 | Wake-up finished; accesses permitted |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, held high |
| oe_no | output | 1 | Output enable, held high |
| addr_o | output | ADDR_W | Address bus, held at zero |

## Verification
The bench builds the block with CLK_NS=10, PAUSE_US=1, REF_ROWS=16, REF_WIN_US=16 and URGENT_LVL=4. This shrinks the power-on pause and the interval tick to 100 cycles each, while the strobe timing keeps its default nanosecond values (1/5/4 cycles). With a 16-row window, a bus hold of 1600 cycles fills the backlog to the loss level, so the repeated wake-up can be reached. An urgency level of 4 lets a five-tick hold show refresh winning over a held request. The backlog values of 0 to 3 let the catch-up burst be counted exactly.

// File: rtl/dram_refresh_pkg.sv
`timescale 1ns/1ps
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_WAKE,
    ST_IDLE,
    ST_REF,
    ST_ACC
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CSU,
    PH_RAS,
    PH_PRE
  } cbr_phase_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refresh_tick_timer.sv
`timescale 1ns/1ps
module refresh_tick_timer #(
  parameter int unsigned PERIOD = 1562
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  generate
    if (PERIOD < 2) begin : g_every_cycle
      assign tick_o = 1'b1;
    end else begin : g_counter
      localparam int unsigned CW = $clog2(PERIOD);
      logic [CW-1:0] cnt_q;
      logic          wrap;

      assign wrap   = (cnt_q == CW'(PERIOD - 1));
      assign tick_o = wrap;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end

      assert_tick_isolated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/refresh_pend_ctr.sv
`timescale 1ns/1ps
module refresh_pend_ctr #(
  parameter int unsigned LOST_LVL   = 2048,
  parameter int unsigned URGENT_LVL = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic nonzero_o,
  output logic urgent_o,
  output logic lost_o
);

  localparam int unsigned PW = $clog2(LOST_LVL + 1);

  logic [PW-1:0] cnt_q;
  logic          do_inc, do_dec;

  assign nonzero_o = (cnt_q != '0);
  assign lost_o    = (cnt_q == PW'(LOST_LVL));
  assign urgent_o  = (cnt_q >= PW'(URGENT_LVL));

  // saturate at the loss level; a decrement at zero is dropped
  assign do_inc = inc_i && !lost_o;
  assign do_dec = dec_i && nonzero_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (do_inc && !do_dec) cnt_q <= cnt_q + 1'b1;
    else if (do_dec && !do_inc) cnt_q <= cnt_q - 1'b1;
  end

  assert_pend_up_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i && !dec_i && !lost_o) |=> (cnt_q == $past(cnt_q) + PW'(1)));

  assert_pend_down_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && dec_i && !inc_i && nonzero_o) |=> (cnt_q == $past(cnt_q) - PW'(1)));

  assert_pend_ceiling_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_o && inc_i && !dec_i && !clr_i) |=> lost_o);

endmodule

// File: rtl/cbr_cycle_engine.sv
`timescale 1ns/1ps
module cbr_cycle_engine
  import dram_refresh_pkg::*;
#(
  parameter int unsigned CSU_CYC = 1,
  parameter int unsigned RAS_CYC = 5,
  parameter int unsigned PRE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic idle_o,
  output logic done_o,
  output logic ras_no,
  output logic cas_no
);

  localparam int unsigned MAXC = max_u(max_u(CSU_CYC, RAS_CYC), PRE_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1);

  cbr_phase_e    phase_q;
  logic [CW-1:0] cnt_q;
  logic          ras_q, cas_q;
  logic          last;

  assign last   = (cnt_q == '0);
  assign idle_o = (phase_q == PH_IDLE);
  assign done_o = (phase_q == PH_PRE) && last;
  assign ras_no = ras_q;
  assign cas_no = cas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_CSU;
          cas_q   <= 1'b0;
          cnt_q   <= CW'(CSU_CYC - 1);
        end
        PH_CSU: if (last) begin
          phase_q <= PH_RAS;
          ras_q   <= 1'b0;
          cnt_q   <= CW'(RAS_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        // both strobes released together; CAS hold after RAS fall is the full RAS width
        PH_RAS: if (last) begin
          phase_q <= PH_PRE;
          ras_q   <= 1'b1;
          cas_q   <= 1'b1;
          cnt_q   <= CW'(PRE_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_PRE: if (last) phase_q <= PH_IDLE;
                else      cnt_q   <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_cas_leads_ras_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_q) |-> (!cas_q && !$past(cas_q)));

  assert_joint_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_q) |-> $rose(cas_q));

  assert_no_cas_in_precharge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PRE) |=> cas_q);

endmodule

// File: rtl/dram_refresh_seq.sv
`timescale 1ns/1ps
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned PAUSE_US    = 200,
  parameter int unsigned WAKE_CYCLES = 8,
  parameter int unsigned REF_ROWS    = 2048,
  parameter int unsigned REF_WIN_US  = 32000,
  parameter int unsigned T_CSR_NS    = 5,
  parameter int unsigned T_RAS_NS    = 50,
  parameter int unsigned T_RP_NS     = 30,
  parameter int unsigned T_RC_NS     = 84,
  parameter int unsigned URGENT_LVL  = 8,
  parameter int unsigned ADDR_W      = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_req_i,
  input  logic              acc_done_i,
  output logic              acc_gnt_o,
  output logic              init_done_o,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic              oe_no,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int unsigned PAUSE_CYC = ceil_div(PAUSE_US * 1000, CLK_NS);
  localparam int unsigned TICK_CYC  = (REF_WIN_US * 1000) / (REF_ROWS * CLK_NS);
  localparam int unsigned CSU_CYC   = max_u(1, ceil_div(T_CSR_NS, CLK_NS));
  localparam int unsigned RAS_CYC   = max_u(1, ceil_div(T_RAS_NS, CLK_NS));
  localparam int unsigned RC_CYC    = ceil_div(T_RC_NS, CLK_NS);
  localparam int unsigned PRE_CYC   = max_u(max_u(1, ceil_div(T_RP_NS, CLK_NS)),
                                            (RC_CYC > RAS_CYC) ? RC_CYC - RAS_CYC : 1);
  localparam int unsigned PC_W      = $clog2(PAUSE_CYC + 1);
  localparam int unsigned WC_W      = $clog2(WAKE_CYCLES + 1);

  seq_state_e      state_q;
  logic [PC_W-1:0] pause_cnt_q;
  logic [WC_W-1:0] wake_cnt_q;
  logic            gnt_q, init_q;

  logic tick, eng_start, eng_idle, eng_done;
  logic pend_clr, pend_dec, pend_nz, pend_urgent, pend_lost;

  refresh_tick_timer #(.PERIOD(TICK_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign pend_clr = (state_q == ST_PAUSE) || (state_q == ST_WAKE);
  assign pend_dec = (state_q == ST_REF) && eng_done;

  refresh_pend_ctr #(.LOST_LVL(REF_ROWS), .URGENT_LVL(URGENT_LVL)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (pend_clr),
    .inc_i     (tick),
    .dec_i     (pend_dec),
    .nonzero_o (pend_nz),
    .urgent_o  (pend_urgent),
    .lost_o    (pend_lost)
  );

  assign eng_start = ((state_q == ST_WAKE) || (state_q == ST_REF)) && eng_idle;

  cbr_cycle_engine #(.CSU_CYC(CSU_CYC), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (eng_start),
    .idle_o  (eng_idle),
    .done_o  (eng_done),
    .ras_no  (ras_no),
    .cas_no  (cas_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_PAUSE;
      pause_cnt_q <= '0;
      wake_cnt_q  <= '0;
      gnt_q       <= 1'b0;
      init_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_PAUSE: begin
          if (pause_cnt_q == PC_W'(PAUSE_CYC - 1)) state_q <= ST_WAKE;
          else                                     pause_cnt_q <= pause_cnt_q + 1'b1;
        end
        ST_WAKE: if (eng_done) begin
          if (wake_cnt_q == WC_W'(WAKE_CYCLES - 1)) begin
            state_q    <= ST_IDLE;
            init_q     <= 1'b1;
            wake_cnt_q <= '0;
          end else begin
            wake_cnt_q <= wake_cnt_q + 1'b1;
          end
        end
        ST_IDLE: begin
          if (pend_lost) begin
            state_q <= ST_WAKE;
            init_q  <= 1'b0;
          end else if (pend_nz && (pend_urgent || !acc_req_i)) begin
            state_q <= ST_REF;
          end else if (acc_req_i) begin
            state_q <= ST_ACC;
            gnt_q   <= 1'b1;
          end
        end
        ST_REF: if (eng_done) state_q <= ST_IDLE;
        ST_ACC: if (acc_done_i) begin
          state_q <= ST_IDLE;
          gnt_q   <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign acc_gnt_o   = gnt_q;
  assign init_done_o = init_q;
  assign we_no       = 1'b1;
  assign oe_no       = 1'b1;
  assign addr_o      = '0;

  assert_quiet_in_pause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAUSE) |-> (ras_no && cas_no));

  assert_grant_needs_init_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_gnt_o |-> init_done_o);

  assert_quiet_bus_on_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_gnt_o |-> (ras_no && cas_no && eng_idle));

  assert_urgent_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && pend_urgent && !pend_lost) |=> !acc_gnt_o);

  assert_lost_restarts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && pend_lost) |=> !init_done_o);

endmodule

// File: tb/dram_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;

  localparam int CLK_NS     = 10;
  localparam int PAUSE_US   = 1;
  localparam int REF_ROWS   = 16;
  localparam int REF_WIN_US = 16;
  localparam int URGENT_LVL = 4;
  localparam int ADDR_W     = 11;

  // expected values from the requirement formulas
  localparam int PAUSE_E = (PAUSE_US * 1000 + CLK_NS - 1) / CLK_NS;
  localparam int TICK_E  = (REF_WIN_US * 1000) / (REF_ROWS * CLK_NS);
  localparam int CSU_E   = 1;
  localparam int RAS_E   = (50 + CLK_NS - 1) / CLK_NS;
  localparam int RP_E    = (30 + CLK_NS - 1) / CLK_NS;
  localparam int RC_E    = (84 + CLK_NS - 1) / CLK_NS;
  localparam int PRE_E   = (RP_E > RC_E - RAS_E) ? RP_E : RC_E - RAS_E;
  localparam int WAKE_E  = 8;

  localparam int VEC_N = 4;
  localparam int VEC_HOLD [VEC_N] = '{4, 99, 199, 299};
  localparam int VEC_EXP  [VEC_N] = '{0, 1, 2, 3};

  logic              clk_i = 1'b0;
  logic              rst_ni, acc_req_i, acc_done_i;
  logic              acc_gnt_o, init_done_o, ras_no, cas_no, we_no, oe_no;
  logic [ADDR_W-1:0] addr_o;

  int n_chk = 0, n_bad = 0, cyc = 0, ref_cnt = 0;
  int fall_at [256];
  int high_run = 0, cas_low_run = 0, ras_low_run = 0;
  logic ras_p = 1'b1, cas_p = 1'b1, gnt_p = 1'b0;
  bit   side_bad = 1'b0;

  always #(CLK_NS / 2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  dram_refresh_seq #(
    .CLK_NS(CLK_NS), .PAUSE_US(PAUSE_US), .REF_ROWS(REF_ROWS),
    .REF_WIN_US(REF_WIN_US), .URGENT_LVL(URGENT_LVL), .ADDR_W(ADDR_W)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_req_i(acc_req_i), .acc_done_i(acc_done_i),
    .acc_gnt_o(acc_gnt_o), .init_done_o(init_done_o), .ras_no(ras_no), .cas_no(cas_no),
    .we_no(we_no), .oe_no(oe_no), .addr_o(addr_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobe timing monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (cas_p && !cas_no) begin
        if (ref_cnt < 256) fall_at[ref_cnt] = cyc;
        ref_cnt++;
        check(ras_no == 1'b1, "R4 cas falls with ras high", int'(ras_no), 1);
        check(high_run >= PRE_E, "R6 precharge before cas fall", high_run, PRE_E);
      end
      if (ras_p && !ras_no)
        check(!cas_no && cas_low_run == CSU_E, "R4 cas lead", cas_low_run, CSU_E);
      if (!ras_p && ras_no) begin
        check(ras_low_run == RAS_E, "R5 ras width", ras_low_run, RAS_E);
        check(cas_no == 1'b1, "R5 joint release", int'(cas_no), 1);
      end
      if (!gnt_p && acc_gnt_o)
        check(high_run >= PRE_E, "R6 precharge before grant", high_run, PRE_E);
      if (acc_gnt_o && !(ras_no && cas_no))
        check(1'b0, "R8 strobes active during grant", int'({ras_no, cas_no}), 3);
      if (acc_gnt_o && !init_done_o)
        check(1'b0, "R3 grant before init", 0, 1);
      if (!we_no || !oe_no || addr_o != '0) side_bad = 1'b1;
      high_run    = (ras_no && cas_no) ? high_run + 1 : 0;
      cas_low_run = cas_no ? 0 : (ras_no ? cas_low_run + 1 : cas_low_run);
      ras_low_run = ras_no ? 0 : ras_low_run + 1;
    end
    ras_p = ras_no;
    cas_p = cas_no;
    gnt_p = acc_gnt_o;
  end

  task automatic wait_fall();
    int base;
    base = ref_cnt;
    while (ref_cnt <= base) @(negedge clk_i);
  endtask

  task automatic wait_gnt();
    while (!acc_gnt_o) @(negedge clk_i);
  endtask

  // sync to a tick-driven refresh, then hold the bus for hold cycles after grant
  task automatic hold_bus(input int hold);
    wait_fall();
    acc_req_i = 1'b1;
    wait_gnt();
    repeat (hold) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rel_cyc, base, t_a, t_b, t_c;
    rst_ni = 1'b0; acc_req_i = 1'b1; acc_done_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(ras_no && cas_no && !acc_gnt_o && !init_done_o, "R1 reset state",
          int'({ras_no, cas_no, acc_gnt_o, init_done_o}), 12);
    rst_ni = 1'b1;
    rel_cyc = cyc;

    // R2 pause, R3 wake count and gating (request held from reset)
    wait_fall();
    check(fall_at[0] - rel_cyc >= PAUSE_E + 1 && fall_at[0] - rel_cyc <= PAUSE_E + 2,
          "R2 pause length", fall_at[0] - rel_cyc, PAUSE_E + 1);
    while (!init_done_o) @(negedge clk_i);
    check(ref_cnt == WAKE_E, "R3 wake cycles before ready", ref_cnt, WAKE_E);
    repeat (2) @(negedge clk_i);
    check(acc_gnt_o == 1'b1, "R8 grant after ready", int'(acc_gnt_o), 1);
    acc_done_i = 1'b1; acc_req_i = 1'b0;
    @(negedge clk_i);
    acc_done_i = 1'b0;
    check(acc_gnt_o == 1'b0, "R8 grant drops after done", int'(acc_gnt_o), 0);

    // R7 tick spacing
    wait_fall(); t_a = fall_at[ref_cnt - 1];
    wait_fall(); t_b = fall_at[ref_cnt - 1];
    wait_fall(); t_c = fall_at[ref_cnt - 1];
    check(t_b - t_a == TICK_E, "R7 spacing a", t_b - t_a, TICK_E);
    check(t_c - t_b == TICK_E, "R7 spacing b", t_c - t_b, TICK_E);

    // R10 catch-up after holds of 0..3 ticks
    for (int i = 0; i < VEC_N; i++) begin
      hold_bus(VEC_HOLD[i]);
      acc_done_i = 1'b1; acc_req_i = 1'b0;
      base = ref_cnt;
      @(negedge clk_i);
      acc_done_i = 1'b0;
      repeat (60) @(negedge clk_i);
      check(ref_cnt - base == VEC_EXP[i], "R10 catch-up burst", ref_cnt - base, VEC_EXP[i]);
    end

    // R9 urgency: backlog 5, request kept high
    hold_bus(5 * TICK_E - 1);
    acc_done_i = 1'b1;
    base = ref_cnt;
    @(negedge clk_i);
    acc_done_i = 1'b0;
    check(acc_gnt_o == 1'b0, "R8 grant released", int'(acc_gnt_o), 0);
    wait_gnt();
    check(ref_cnt - base == 2, "R9 refresh before grant", ref_cnt - base, 2);
    repeat (5) @(negedge clk_i);
    acc_done_i = 1'b1; acc_req_i = 1'b0;
    @(negedge clk_i);
    acc_done_i = 1'b0;
    repeat (60) @(negedge clk_i);

    // R11 lost window
    hold_bus(REF_ROWS * TICK_E - 1);
    acc_done_i = 1'b1; acc_req_i = 1'b0;
    @(negedge clk_i);
    acc_done_i = 1'b0;
    @(negedge clk_i);
    check(init_done_o == 1'b0, "R11 ready withdrawn", int'(init_done_o), 0);
    base = ref_cnt;
    while (!init_done_o) @(negedge clk_i);
    check(ref_cnt - base == WAKE_E, "R11 wake repeated", ref_cnt - base, WAKE_E);

    repeat (20) @(negedge clk_i);
    check(!side_bad && we_no && oe_no && addr_o == '0, "R12 idle pins",
          int'(side_bad), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule